// File: doc/BRIEF.md
# Blank/Render Sync Phase Sequencer

The sequencer runs one free cycle counter and drives two timelines from it. The horizontal timeline alternates between a render part and a blank part of each scanline. The vertical timeline alternates between a render period and a blank period. All four phase lengths come from input registers and are given in cycles.

Each phase boundary is the previous boundary plus the length of the phase that follows it. No cycles are lost when a phase changes. Integer line lengths do not add up exactly to the vertical period, so every vertical-blank start moves the next horizontal boundary later by a stored correction count.

The block raises one-cycle strobes at each blank start and each blank end. It also keeps two sticky status bits, one for horizontal sync and one for vertical sync. Each status bit has its own maskable interrupt pulse and is cleared by writing a 1 to it. A frame counter counts the vertical periods.

Top module: `scan_phase_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the block returns to its reset state. The cycle after reset shows `hblank`=0, `vblank`=0, every strobe at 0, both status bits at 0, both interrupt lines at 0 and `frame_count`=0.
- R2: Both timelines start in render after reset. The horizontal timeline stays in render for `hrender_len` cycles, then in blank for `hblank_len` cycles, and keeps alternating. `hblank` rises on the edge where the counter, which is 0 just after reset, equals the boundary.
- R3: The vertical timeline alternates in the same way, with `vrender_len` cycles of render (`vblank`=0) and `vblank_len` cycles of blank (`vblank`=1).
- R4: Each new boundary equals the old boundary plus the length of the phase being entered. Over any number of phases, no timeline gains or loses a cycle. Every length must be at least 1.
- R5: On the edge that starts vertical blank, the pending horizontal boundary moves later by `hsync_err` cycles. If a horizontal boundary falls on that same edge, the new boundary also receives the correction.
- R6: `hblank_start`, `hblank_end`, `vblank_start` and `vblank_end` are one-cycle pulses. Each pulse appears in the same cycle as the matching change of the `hblank` or `vblank` level.
- R7: Vertical blank start sets `vsync_stat`. `vsync_irq` pulses for one cycle only if that bit was clear before the edge and `irq_mask[11]` is 0. Other mask bits have no effect on it.
- R8: Horizontal blank end sets `hsync_stat`. `hsync_irq` pulses for one cycle only if that bit was clear before the edge and `irq_mask[10]` is 0.
- R9: A write with `stat_clr_we`=1 clears the status bits whose positions in `stat_clr_bits` are 1: bit 0 is horizontal and bit 1 is vertical. If a clear and a set reach the same bit in the same cycle, the bit stays set.
- R10: `frame_count` increases by one at each vertical blank end and wraps at its width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hrender_len | input | LW (16) | Horizontal render length in cycles |
| hblank_len | input | LW (16) | Horizontal blank length in cycles |
| vrender_len | input | LW (16) | Vertical render length in cycles |
| vblank_len | input | LW (16) | Vertical blank length in cycles |
| hsync_err | input | LW (16) | Horizontal realignment added at each vertical blank start |
| irq_mask | input | MW (16) | Interrupt mask; bit 10 masks horizontal, bit 11 masks vertical |
| stat_clr_we | input | 1 | Status clear write strobe |
| stat_clr_bits | input | 2 | Write-1-to-clear data; bit 0 horizontal, bit 1 vertical |
| hblank | output | 1 | Horizontal blank level |
| vblank | output | 1 | Vertical blank level |
| hblank_start | output | 1 | Horizontal blank start strobe |
| hblank_end | output | 1 | Horizontal blank end strobe |
| vblank_start | output | 1 | Vertical blank start strobe |
| vblank_end | output | 1 | Vertical blank end strobe |
| hsync_stat | output | 1 | Sticky horizontal sync status |
| vsync_stat | output | 1 | Sticky vertical sync status |
| hsync_irq | output | 1 | Horizontal sync interrupt pulse |
| vsync_irq | output | 1 | Vertical sync interrupt pulse |
| frame_count | output | FW (16) | Frame counter |

## Verification
Some properties hold on every cycle, and the assertions check them:
- strobes never clash, and every level change carries its strobe;
- an interrupt fires only for a bit that was clear and unmasked;
- a status bit drops only after a clear request;
- a status bit rises or the frame count moves only together with the matching strobe.

Cycle-exact phase lengths, the absence of drift over many lines, and the horizontal shift at each vertical blank start can only be shown over long runs. The bench runs such scenarios and compares every output, on every cycle, with a down-counting reference model. The scenarios include lengths of one cycle and a clear that coincides with a set.

// File: rtl/scan_phase_pkg.sv
package scan_phase_pkg;

    typedef enum logic {
        PH_RENDER = 1'b0,
        PH_BLANK  = 1'b1
    } phase_e;

    typedef struct packed {
        logic start;
        logic stop;
    } edge_pulse_t;

    localparam int HS_MASK_BIT = 10;
    localparam int VS_MASK_BIT = 11;
    localparam int CLR_HS_BIT  = 0;
    localparam int CLR_VS_BIT  = 1;

    function automatic logic sticky_next(input logic cur, input logic clr, input logic set);
        return (cur && !clr) || set;
    endfunction

endpackage

// File: rtl/phase_timer.sv
module phase_timer
    import scan_phase_pkg::*;
#(
    parameter int CW = 32,
    parameter int LW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] now,
    input  logic [LW-1:0] render_len,
    input  logic [LW-1:0] blank_len,
    input  logic          shift_en,
    input  logic [LW-1:0] shift_amt,
    output logic          blank_lvl,
    output edge_pulse_t   pulse_now,
    output edge_pulse_t   pulse_q
);
    localparam int PAD = CW - LW;

    logic [CW-1:0] bound_q, bound_d;
    phase_e        ph_q, ph_d;
    logic          hit;

    assign hit = (now == bound_q);

    always_comb begin
        bound_d   = bound_q;
        ph_d      = ph_q;
        pulse_now = '0;
        if (hit) begin
            if (ph_q == PH_RENDER) begin
                ph_d            = PH_BLANK;
                bound_d         = bound_q + {{PAD{1'b0}}, blank_len};
                pulse_now.start = 1'b1;
            end else begin
                ph_d           = PH_RENDER;
                bound_d        = bound_q + {{PAD{1'b0}}, render_len};
                pulse_now.stop = 1'b1;
            end
        end
        if (shift_en) begin
            bound_d = bound_d + {{PAD{1'b0}}, shift_amt};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bound_q <= {{PAD{1'b0}}, render_len};
            ph_q    <= PH_RENDER;
            pulse_q <= '0;
        end else begin
            bound_q <= bound_d;
            ph_q    <= ph_d;
            pulse_q <= pulse_now;
        end
    end

    assign blank_lvl = (ph_q == PH_BLANK);

    // R6: strobes exclusive and tied to level changes
    assert_strobe_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
        !(pulse_q.start && pulse_q.stop));
    assert_start_in_blank_R6: assert property (@(posedge clk) disable iff (rst)
        pulse_q.start |-> blank_lvl);
    assert_stop_in_render_R6: assert property (@(posedge clk) disable iff (rst)
        pulse_q.stop |-> !blank_lvl);
    assert_level_change_strobed_R6: assert property (@(posedge clk) disable iff (rst)
        (blank_lvl != $past(blank_lvl)) |-> (pulse_q.start || pulse_q.stop));

endmodule

// File: rtl/sync_status.sv
module sync_status
    import scan_phase_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    input  logic mask_i,
    output logic stat_o,
    output logic irq_o
);
    logic stat_q;
    logic irq_q;
    logic newly;

    assign newly = set_i && !stat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            stat_q <= sticky_next(stat_q, clr_i, set_i);
            irq_q  <= newly && !mask_i;
        end
    end

    assign stat_o = stat_q;
    assign irq_o  = irq_q;

    // R7 R8: an interrupt only for a bit that was clear and unmasked
    assert_irq_only_new_R7: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (stat_o && !$past(stat_o)));
    assert_irq_unmasked_R8: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> !$past(mask_i));
    // R9: a status bit drops only after a clear, and rises only on a set
    assert_fall_needs_clear_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(stat_o) |-> $past(clr_i));
    assert_rise_needs_set_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(stat_o) |-> $past(set_i));

endmodule

// File: rtl/scan_phase_seq.sv
module scan_phase_seq
    import scan_phase_pkg::*;
#(
    parameter int CW = 32,
    parameter int LW = 16,
    parameter int FW = 16,
    parameter int MW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [LW-1:0] hrender_len,
    input  logic [LW-1:0] hblank_len,
    input  logic [LW-1:0] vrender_len,
    input  logic [LW-1:0] vblank_len,
    input  logic [LW-1:0] hsync_err,
    input  logic [MW-1:0] irq_mask,
    input  logic          stat_clr_we,
    input  logic [1:0]    stat_clr_bits,
    output logic          hblank,
    output logic          vblank,
    output logic          hblank_start,
    output logic          hblank_end,
    output logic          vblank_start,
    output logic          vblank_end,
    output logic          hsync_stat,
    output logic          vsync_stat,
    output logic          hsync_irq,
    output logic          vsync_irq,
    output logic [FW-1:0] frame_count
);
    logic [CW-1:0] now_q;
    edge_pulse_t   h_now, h_q, v_now, v_q;
    logic [FW-1:0] frame_q;

    always_ff @(posedge clk) begin
        if (rst) now_q <= '0;
        else     now_q <= now_q + 1'b1;
    end

    phase_timer #(.CW(CW), .LW(LW)) u_vert (
        .clk(clk), .rst(rst), .now(now_q),
        .render_len(vrender_len), .blank_len(vblank_len),
        .shift_en(1'b0), .shift_amt('0),
        .blank_lvl(vblank), .pulse_now(v_now), .pulse_q(v_q)
    );

    phase_timer #(.CW(CW), .LW(LW)) u_horz (
        .clk(clk), .rst(rst), .now(now_q),
        .render_len(hrender_len), .blank_len(hblank_len),
        .shift_en(v_now.start), .shift_amt(hsync_err),
        .blank_lvl(hblank), .pulse_now(h_now), .pulse_q(h_q)
    );

    sync_status u_hs (
        .clk(clk), .rst(rst), .set_i(h_now.stop),
        .clr_i(stat_clr_we && stat_clr_bits[CLR_HS_BIT]),
        .mask_i(irq_mask[HS_MASK_BIT]),
        .stat_o(hsync_stat), .irq_o(hsync_irq)
    );

    sync_status u_vs (
        .clk(clk), .rst(rst), .set_i(v_now.start),
        .clr_i(stat_clr_we && stat_clr_bits[CLR_VS_BIT]),
        .mask_i(irq_mask[VS_MASK_BIT]),
        .stat_o(vsync_stat), .irq_o(vsync_irq)
    );

    always_ff @(posedge clk) begin
        if (rst)             frame_q <= '0;
        else if (v_now.stop) frame_q <= frame_q + 1'b1;
    end

    assign frame_count  = frame_q;
    assign hblank_start = h_q.start;
    assign hblank_end   = h_q.stop;
    assign vblank_start = v_q.start;
    assign vblank_end   = v_q.stop;

    // R10: frame count moves only with the vertical blank end strobe
    assert_frame_with_vend_R10: assert property (@(posedge clk) disable iff (rst)
        (frame_count != $past(frame_count)) |-> vblank_end);
    // R8: horizontal status rises only with the horizontal blank end strobe
    assert_hs_rise_at_hend_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(hsync_stat) |-> hblank_end);
    // R7: vertical status rises only with the vertical blank start strobe
    assert_vs_rise_at_vstart_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(vsync_stat) |-> vblank_start);

endmodule

// File: tb/sim_scan_phase_seq.sv
module sim_scan_phase_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] hr, hb, vr, vb, err, mask;
    logic        clr_we;
    logic [1:0]  clr_bits;
    logic        hblank, vblank, hbs, hbe, vbs, vbe, hst, vst, hirq, virq;
    logic [15:0] frame;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // reference model state
    int  m_hrem, m_vrem, m_frame;
    bit  m_hbl, m_vbl, m_hbs, m_hbe, m_vbs, m_vbe, m_hst, m_vst, m_hirq, m_virq;

    always #10 clk = ~clk;

    scan_phase_seq u0 (
        .clk(clk), .rst(rst),
        .hrender_len(hr), .hblank_len(hb), .vrender_len(vr), .vblank_len(vb),
        .hsync_err(err), .irq_mask(mask),
        .stat_clr_we(clr_we), .stat_clr_bits(clr_bits),
        .hblank(hblank), .vblank(vblank),
        .hblank_start(hbs), .hblank_end(hbe),
        .vblank_start(vbs), .vblank_end(vbe),
        .hsync_stat(hst), .vsync_stat(vst),
        .hsync_irq(hirq), .vsync_irq(virq),
        .frame_count(frame)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_hrem = int'(hr); m_vrem = int'(vr); m_frame = 0;
        m_hbl = 0; m_vbl = 0; m_hbs = 0; m_hbe = 0; m_vbs = 0; m_vbe = 0;
        m_hst = 0; m_vst = 0; m_hirq = 0; m_virq = 0;
    endtask

    task automatic model_step();
        bit hev, vev, hclr, vclr;
        hev = (m_hrem == 0);
        vev = (m_vrem == 0);
        m_hbs = 0; m_hbe = 0; m_vbs = 0; m_vbe = 0;
        if (hev) begin
            if (m_hbl) begin m_hbe = 1; m_hbl = 0; m_hrem = int'(hr) - 1; end
            else       begin m_hbs = 1; m_hbl = 1; m_hrem = int'(hb) - 1; end
        end else m_hrem--;
        if (vev) begin
            if (m_vbl) begin m_vbe = 1; m_vbl = 0; m_vrem = int'(vr) - 1; m_frame = (m_frame + 1) & 16'hFFFF; end
            else       begin m_vbs = 1; m_vbl = 1; m_vrem = int'(vb) - 1; end
        end else m_vrem--;
        if (m_vbs) m_hrem += int'(err);
        hclr = clr_we && clr_bits[0];
        vclr = clr_we && clr_bits[1];
        m_hirq = m_hbe && !m_hst && !mask[10];
        m_virq = m_vbs && !m_vst && !mask[11];
        m_hst = (m_hst && !hclr) || m_hbe;
        m_vst = (m_vst && !vclr) || m_vbs;
    endtask

    task automatic compare_all();
        chk("R2 R4 R5 hblank", int'(hblank), int'(m_hbl));
        chk("R3 R4 vblank", int'(vblank), int'(m_vbl));
        chk("R6 hblank_start", int'(hbs), int'(m_hbs));
        chk("R6 hblank_end", int'(hbe), int'(m_hbe));
        chk("R6 vblank_start", int'(vbs), int'(m_vbs));
        chk("R6 vblank_end", int'(vbe), int'(m_vbe));
        chk("R8 R9 hsync_stat", int'(hst), int'(m_hst));
        chk("R7 R9 vsync_stat", int'(vst), int'(m_vst));
        chk("R8 hsync_irq", int'(hirq), int'(m_hirq));
        chk("R7 vsync_irq", int'(virq), int'(m_virq));
        chk("R10 frame_count", int'(frame), m_frame);
    endtask

    task automatic do_reset(input int h_r, input int h_b, input int v_r, input int v_b, input int e);
        @(negedge clk);
        rst = 1'b1;
        hr = 16'(h_r); hb = 16'(h_b); vr = 16'(v_r); vb = 16'(v_b); err = 16'(e);
        clr_we = 1'b0; clr_bits = 2'b00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_reset();
        chk("R1 hblank", int'(hblank), 0);
        chk("R1 vblank", int'(vblank), 0);
        chk("R1 strobes", int'({hbs, hbe, vbs, vbe}), 0);
        chk("R1 status", int'({hst, vst}), 0);
        chk("R1 irq", int'({hirq, virq}), 0);
        chk("R1 frame", int'(frame), 0);
    endtask

    task automatic step(input logic we, input logic [1:0] bits);
        clr_we = we; clr_bits = bits;
        @(posedge clk);
        #1 model_step();
        @(negedge clk);
        compare_all();
    endtask

    task automatic run_random(input int n);
        for (int i = 0; i < n; i++) begin
            if (($urandom % 32) == 0) mask = 16'($urandom);
            step(($urandom % 6) == 0, 2'($urandom));
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        hr = 16'd1; hb = 16'd1; vr = 16'd1; vb = 16'd1; err = 16'd0;
        mask = 16'h0000; clr_we = 1'b0; clr_bits = 2'b00;

        // directed: correction shift, unmasked
        do_reset(3, 3, 17, 7, 2);
        for (int i = 0; i < 300; i++) step(1'b0, 2'b00);
        // directed: clear every cycle so each set collides with a clear (R9)
        for (int i = 0; i < 200; i++) step(1'b1, 2'b11);
        // directed: one-cycle phases, both interrupts masked (R7 R8)
        mask = 16'h0C00;
        do_reset(1, 1, 5, 1, 0);
        for (int i = 0; i < 150; i++) step(1'b1, 2'($urandom));
        // directed: other mask bits only
        mask = 16'hF3FF;
        do_reset(2, 1, 9, 3, 1);
        for (int i = 0; i < 150; i++) step(($urandom % 3) == 0, 2'b11);
        // random scenarios
        for (int s = 0; s < 6; s++) begin
            mask = 16'($urandom);
            do_reset(1 + int'($urandom % 8), 1 + int'($urandom % 8),
                     6 + int'($urandom % 40), 1 + int'($urandom % 20),
                     int'($urandom % 4));
            run_random(500);
        end
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog act=1 exp=0");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule